// File: doc/BRIEF.md
# Switch Egress-Port Tag Inserter

This block sits on the byte-wide stream that carries frames from the host processor into an Ethernet switch. At byte offset 12, right after the two 6-byte MAC addresses, it places a 4-byte forwarding tag. The tag names the switch port the frame must leave on and says whether it is merged with an 802.1Q header.

The block reads bytes 12 and 13 to decide which layout to use. When they hold the VLAN TPID 0x8100, those two bytes are overwritten by the tag's attribute and port-mask bytes. The VLAN TCI that follows then serves as the last two tag bytes, and the frame length stays the same. Any other frame receives four new bytes and grows by four.

Both stream sides use valid/ready with a last marker. A byte moves only in a cycle where valid and ready are both high. The sender must hold valid, data and last steady until the byte is accepted. The block holds its own output steady while `out_ready` is low. Back-pressure at the output reaches the input in the same cycle during the address bytes and the frame body. While tag or held bytes are being emitted, `in_ready` is low.

Top module: `stag_inserter`

## Requirements
- R1: After reset `out_valid` is low and, with `out_ready` high and no input offered, `in_ready` is high.
- R2: Bytes 0 to 11 of every frame leave unchanged and in order, and the tag always starts at output byte 12.
- R3: A frame of 14 or more bytes that is not tagged (see R4) is output as bytes 0-11, then 0x00, the port mask, 0x00, 0x00, then input bytes 12 onward. The output is 4 bytes longer than the input.
- R4: A frame is tagged when input byte 12 is 0x81, byte 13 is 0x00, and byte 13 is not the last byte. Such a frame is output with byte 12 replaced by 0x01 and byte 13 by the port mask. All other bytes are unchanged and the length is the same.
- R5: The port mask byte is 1 shifted left by the 3-bit `in_port` value when that value is 0 to 5, and 0x00 for 6 or 7. `in_port` is read only on the first byte of each frame.
- R6: A frame of 12 bytes or fewer leaves unchanged.
- R7: A 13-byte frame is output as bytes 0-11, the untagged tag, then byte 12 as the last byte. A 14-byte frame ending in 0x81 0x00 is handled as untagged.
- R8: While `out_valid` is high and `out_ready` low, `out_data` and `out_last` stay stable. No byte is lost or repeated under any ready pattern.
- R9: `out_last` is high on exactly one byte per frame, the final output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| in_port | input | 3 | Destination port index, read on the first byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The address bytes and the frame body pass through without a register, so each of them appears on the output in the same cycle it is offered, and the block accepts it when the downstream accepts it. Bytes 12 and 13 are each taken into a holding register on their own input handshake. The first tag byte is driven in the cycle after byte 13 is taken, or after byte 12 is taken when byte 12 is the last byte. The tag bytes and held bytes then follow one per accepted output cycle. For these reasons the bench drives inputs on the falling edge and samples both handshakes 2 ns later. It collects each frame byte by byte until `out_last` and compares the whole frame, so latency that varies with the ready pattern cannot move a check.

// File: rtl/stag_pkg.sv
package stag_pkg;
  typedef enum logic [2:0] {
    ST_ADDR = 3'd0,
    ST_PEEK = 3'd1,
    ST_TAG  = 3'd2,
    ST_HOLD = 3'd3,
    ST_BODY = 3'd4
  } stag_state_e;

  localparam logic [7:0] ATTR_PLAIN  = 8'h00;
  localparam logic [7:0] ATTR_MERGED = 8'h01;
endpackage

// File: rtl/stag_port_mask.sv
module stag_port_mask #(
  parameter int PORT_W     = 3,
  parameter int MASK_PORTS = 6
) (
  input  logic [PORT_W-1:0] port,
  output logic [7:0]        mask
);
  localparam int IDX_LIMIT = 1 << PORT_W;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    if (g < MASK_PORTS && g < IDX_LIMIT) begin : g_live
      assign mask[g] = (port == PORT_W'(g));
    end else begin : g_dead
      assign mask[g] = 1'b0;
    end
  end
endmodule

// File: rtl/stag_peek.sv
module stag_peek #(
  parameter logic [7:0] TPID_HI = 8'h81,
  parameter logic [7:0] TPID_LO = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_first,
  input  logic       cap_second,
  input  logic [7:0] din,
  output logic [7:0] held_first,
  output logic [7:0] held_second,
  output logic       tpid_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_first  <= 8'h00;
      held_second <= 8'h00;
    end else begin
      if (cap_first)  held_first  <= din;
      if (cap_second) held_second <= din;
    end
  end

  // compares the captured first byte with the byte on the input now
  assign tpid_hit = (held_first == TPID_HI) && (din == TPID_LO);
endmodule

// File: rtl/stag_inserter.sv
module stag_inserter
  import stag_pkg::*;
#(
  parameter int          ADDR_BYTES = 12,
  parameter int          PORT_W     = 3,
  parameter int          MASK_PORTS = 6,
  parameter logic [7:0]  TPID_HI    = 8'h81,
  parameter logic [7:0]  TPID_LO    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int CNT_W = ($clog2(ADDR_BYTES) > 2) ? $clog2(ADDR_BYTES) : 2;
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(3);

  stag_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PORT_W-1:0] port_q;
  logic              merged_q;
  logic              held_two_q;
  logic              held_last_q;
  logic [7:0]        mask;
  logic [7:0]        held_first, held_second;
  logic              tpid_hit;
  logic              in_fire, out_fire;
  logic              cap_first, cap_second;

  stag_port_mask #(.PORT_W(PORT_W), .MASK_PORTS(MASK_PORTS)) u_mask (
    .port (port_q),
    .mask (mask)
  );

  stag_peek #(.TPID_HI(TPID_HI), .TPID_LO(TPID_LO)) u_peek (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_first   (cap_first),
    .cap_second  (cap_second),
    .din         (in_data),
    .held_first  (held_first),
    .held_second (held_second),
    .tpid_hit    (tpid_hit)
  );

  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign cap_first  = (state_q == ST_PEEK) && (cnt_q == '0) && in_fire;
  assign cap_second = (state_q == ST_PEEK) && (cnt_q != '0) && in_fire;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    unique case (state_q)
      ST_ADDR, ST_BODY: begin
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last;
        in_ready  = out_ready;
      end
      ST_PEEK: begin
        in_ready = 1'b1;
      end
      ST_TAG: begin
        out_valid = 1'b1;
        unique case (cnt_q[1:0])
          2'd0:    out_data = merged_q ? ATTR_MERGED : ATTR_PLAIN;
          2'd1:    out_data = mask;
          default: out_data = 8'h00;
        endcase
      end
      ST_HOLD: begin
        out_valid = 1'b1;
        out_data  = cnt_q[0] ? held_second : held_first;
        out_last  = held_last_q && (cnt_q[0] == held_two_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_ADDR;
      cnt_q       <= '0;
      port_q      <= '0;
      merged_q    <= 1'b0;
      held_two_q  <= 1'b0;
      held_last_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (in_fire) begin
            if (cnt_q == '0) port_q <= in_port;
            if (in_last) begin
              cnt_q <= '0;
            end else if (cnt_q == ADDR_END) begin
              cnt_q   <= '0;
              state_q <= ST_PEEK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_PEEK: begin
          if (in_fire) begin
            if (cnt_q == '0) begin
              if (in_last) begin
                merged_q    <= 1'b0;
                held_two_q  <= 1'b0;
                held_last_q <= 1'b1;
                state_q     <= ST_TAG;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else begin
              cnt_q       <= '0;
              state_q     <= ST_TAG;
              merged_q    <= tpid_hit && !in_last;
              held_two_q  <= 1'b1;
              held_last_q <= in_last;
            end
          end
        end
        ST_TAG: begin
          if (out_fire) begin
            if (merged_q && cnt_q == CNT_W'(1)) begin
              cnt_q   <= '0;
              state_q <= ST_BODY;
            end else if (cnt_q == TAG_END) begin
              cnt_q   <= '0;
              state_q <= ST_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (out_fire) begin
            if (cnt_q[0] == held_two_q) begin
              cnt_q   <= '0;
              state_q <= held_last_q ? ST_ADDR : ST_BODY;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_BODY: begin
          if (in_fire && in_last) begin
            cnt_q   <= '0;
            state_q <= ST_ADDR;
          end
        end
        default: state_q <= ST_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/stag_inserter_chk.sv
module stag_inserter_chk
  import stag_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input stag_state_e      state_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             merged_q,
  input logic [7:0]       mask
);
  logic tag_phase;
  assign tag_phase = (state_q == ST_TAG) || (state_q == ST_HOLD);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && tag_phase)
      |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_mask_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));

  p_attr_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && state_q == ST_TAG && cnt_q == '0)
      |-> (out_data[7:1] == 7'd0 && !out_last));

  p_merge_body_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && state_q == ST_TAG && merged_q && cnt_q == CNT_W'(1))
      |=> (state_q == ST_BODY));

  p_plain_tag_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && state_q == ST_TAG && !merged_q && cnt_q == CNT_W'(3))
      |=> (state_q == ST_HOLD));

  p_short_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && state_q == ST_ADDR)
      |=> (state_q == ST_ADDR && cnt_q == '0));
endmodule

bind stag_inserter stag_inserter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .state_q   (state_q),
  .cnt_q     (cnt_q),
  .merged_q  (merged_q),
  .mask      (mask)
);

// File: tb/sim_stag_inserter.sv
`timescale 1ns/1ps
module sim_stag_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic [2:0] in_port = 3'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  stag_inserter u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_port(in_port),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  // vector fields: {len[7:0], port[2:0], mode[1:0], ready_pattern[1:0]}
  // mode: 0 plain bytes, 1 bytes 12/13 = 81 00, 2 bytes 12/13 = 81 55
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {8'd20, 3'd0, 2'd0, 2'd0},
    {8'd20, 3'd3, 2'd1, 2'd0},
    {8'd30, 3'd5, 2'd0, 2'd1},
    {8'd25, 3'd2, 2'd1, 2'd2},
    {8'd8,  3'd1, 2'd0, 2'd0},
    {8'd12, 3'd4, 2'd0, 2'd1},
    {8'd13, 3'd2, 2'd0, 2'd2},
    {8'd14, 3'd1, 2'd1, 2'd0},
    {8'd18, 3'd6, 2'd0, 2'd0},
    {8'd16, 3'd7, 2'd1, 2'd1},
    {8'd20, 3'd0, 2'd2, 2'd2},
    {8'd1,  3'd3, 2'd0, 2'd2}
  };

  logic [7:0] frm [64];
  logic [7:0] exp_b [64];
  logic [7:0] got [64];
  int exp_n, got_n;
  int early_last;

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run_vec(input int len, input int port, input int mode,
                         input int rdy, input string req);
    int idx;
    bit done;
    int spin;
    logic [7:0] m;
    bit merged;
    int bad;
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 13 + port * 5 + 3) & 8'hff);
    if (mode != 0 && len > 12) frm[12] = 8'h81;
    if (mode == 1 && len > 13) frm[13] = 8'h00;
    if (mode == 2 && len > 13) frm[13] = 8'h55;
    m = (port < 6) ? 8'(1 << port) : 8'h00;
    exp_n = 0;
    if (len <= 12) begin
      for (int i = 0; i < len; i++) begin exp_b[exp_n] = frm[i]; exp_n++; end
    end else begin
      merged = (len > 14) && frm[12] == 8'h81 && frm[13] == 8'h00;
      for (int i = 0; i < 12; i++) begin exp_b[exp_n] = frm[i]; exp_n++; end
      exp_b[exp_n] = merged ? 8'h01 : 8'h00; exp_n++;
      exp_b[exp_n] = m; exp_n++;
      if (!merged) begin
        exp_b[exp_n] = 8'h00; exp_n++;
        exp_b[exp_n] = 8'h00; exp_n++;
      end
      for (int i = (merged ? 14 : 12); i < len; i++) begin
        exp_b[exp_n] = frm[i]; exp_n++;
      end
    end
    idx = 0; got_n = 0; done = 0; spin = 0; early_last = 0;
    while (!done && spin < 500) begin
      @(negedge clk);
      in_valid  = (idx < len);
      in_data   = (idx < len) ? frm[idx] : 8'h00;
      in_last   = (idx == len - 1);
      in_port   = (idx == 0) ? 3'(port) : ~3'(port);
      out_ready = (rdy == 0) ? 1'b1 : (rdy == 1) ? cyc[0] : lfsr[3];
      #2;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        if (got_n < 64) got[got_n] = out_data;
        got_n++;
        if (out_last) done = 1;
      end
      spin++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    note(done && got_n == exp_n, req, "frame length", got_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got[i] !== exp_b[i]) bad = i;
    if (bad >= 0)
      note(1'b0, req, $sformatf("byte %0d (len %0d port %0d)", bad, len, port),
           got[bad], exp_b[bad]);
    else
      note(1'b1, req, "frame bytes", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    note(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    note(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    for (int v = 0; v < NV; v++) begin
      run_vec(int'(VEC[v][14:7]), int'(VEC[v][6:4]), int'(VEC[v][3:2]),
              int'(VEC[v][1:0]), "R2 R3 R4 R5 R8 R9");
    end

    // directed corner cases
    run_vec(5,  2, 0, 2, "R6");
    run_vec(13, 0, 1, 1, "R7");
    run_vec(14, 5, 1, 2, "R7");
    run_vec(15, 4, 1, 2, "R4");
    run_vec(40, 1, 0, 2, "R3 R8");
    run_vec(40, 7, 1, 2, "R5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule